// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 18-bit words that sits between two unrelated clock domains. A producer pushes words on the write clock, and a consumer pulls them on the read clock. The two clocks may run at any ratio. No input says which clock is the faster one. The depth is a power-of-two parameter, and the storage is a register array indexed by binary pointers. Each pointer also crosses to the opposite domain as Gray code through a two-stage synchronizer.

Besides the plain empty and full indications, the block raises a half-full flag and two threshold flags, almost-empty and almost-full. Each threshold flag is compared against its own offset register. The offsets come up at one of two built-in defaults after a master reset. Software can then reprogram them, either with a parallel strobe that takes the value from the data bus or by shifting bits in one per write clock.

During master reset the block samples a timing-mode input. In standard timing, the consumer requests each word and sees it on the next read edge. In fall-through timing, the oldest word is presented on the output before any request, and the two status outputs act as ready indications. A partial reset empties the buffer but keeps the programmed offsets. A retransmit input rewinds the reader to the first word written since the last reset.

Top module: `dcfifo_pflag`

## Requirements
- R1: Every accepted word leaves the read port exactly once, in write order, whatever the ratio of the two clocks. A write is accepted when `wen`=1, `ld_par`=0 and the buffer is not full at the write edge. The buffer holds up to DEPTH words (default 256).
- R2: In standard timing (`fwft_sel`=0 during master reset), `rd_stat`=1 exactly when no word is readable and `wr_stat`=1 exactly when DEPTH words are held. A read edge with `ren`=1 and a word available loads the oldest word into `dout`, visible after that edge.
- R3: A write while full is dropped. A read while empty is dropped and `dout` keeps its value. Neither moves a pointer, so the next accepted word is the next one returned.
- R4: In fall-through timing (`fwft_sel`=1 during master reset), `rd_stat`=1 while a word is available, and `dout` then shows the oldest word without any request. A read edge with `ren`=1 consumes that word. `wr_stat`=1 while at least one slot is free.
- R5: `hf`=1 exactly when the occupancy is greater than DEPTH/2.
- R6: `ae`=1 when the occupancy is at or below the almost-empty offset. `af`=1 when the free space is at or below the almost-full offset.
- R7: Master reset (`mrst_n`=0) empties the buffer and loads both offsets with the same default: 7 when `def_sel`=0, or 63 when `def_sel`=1. Both `def_sel` and `fwft_sel` are sampled while master reset is held.
- R8: Partial reset (`prst_n`=0) empties the buffer but leaves both offsets as last programmed.
- R9: A write edge with `ld_par`=1 stores `din[log2(DEPTH)-1:0]` into the almost-empty offset on the first strobe after any reset and into the almost-full offset on the next, alternating from then on. No data word is written on that edge.
- R10: Each write edge with `ser_en`=1 shifts in `ser_in`. After 2·log2(DEPTH) shifts, the first log2(DEPTH) bits form the almost-empty offset, least significant bit first, and the rest form the almost-full offset in the same bit order.
- R11: A read edge with `rt`=1 rewinds the read side to the first location written since the last reset. All words written since then become readable again, in order. Writes must be idle around a retransmit.
- R12: Each pointer's Gray form changes in at most one bit per clock of its own domain, except on a retransmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Timing mode, sampled during master reset (1 = fall-through) |
| def_sel | input | 1 | Default offset choice, sampled during master reset (0 = 7, 1 = 63) |
| din | input | 18 | Write data, also the parallel offset value |
| wen | input | 1 | Write enable |
| ld_par | input | 1 | Parallel offset load strobe |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset bit |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| af | output | 1 | Almost-full flag |
| hf | output | 1 | Half-full flag |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| dout | output | 18 | Read data |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| ae | output | 1 | Almost-empty flag |

## Verification
The bench steps the occupancy across each threshold one word at a time: the default offsets 7 and 63, the half-depth mark, the last free slot and one word past it. A comparison with an off-by-one error shows up as a flag that changes state one word early or late. It then presses on a full buffer and reads an empty one. A design that moved a pointer on those edges would replay stale data or skip a word in the drained sequence. Offsets are loaded in parallel (with a write attempted on the same edge) and serially, and they are then checked to survive a partial reset and to fall back to the defaults on a master reset. Swapped serial fields, reversed bit order or a lost offset would all move the flag crossing points. Retransmit and randomised traffic are run in both timing modes; a broken rewind or an unsafe pointer crossing returns words out of order.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {TM_STD = 1'b0, TM_FWFT = 1'b1} tmode_e;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      q       <= '0;
    end else begin
      stage_q <= d;
      q       <= stage_q;
    end
  end
endmodule

// File: rtl/dcf_offsets.sv
module dcf_offsets #(
  parameter int OW     = 8,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 63
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          mrst_n,
  input  logic          def_sel,
  input  logic          ld_par,
  input  logic [OW-1:0] par_val,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic [OW-1:0] ae_ofs,
  output logic [OW-1:0] af_ofs
);
  localparam logic [OW-1:0] LO = OW'(DEF_LO);
  localparam logic [OW-1:0] HI = OW'(DEF_HI);

  logic [OW-1:0] ae_q, ae_d, af_q, af_d;
  logic          idx_q, idx_d;

  always_comb begin
    ae_d  = ae_q;
    af_d  = af_q;
    idx_d = idx_q;
    if (!mrst_n) begin
      ae_d = def_sel ? HI : LO;
      af_d = def_sel ? HI : LO;
    end else if (ld_par) begin
      if (!idx_q) ae_d = par_val;
      else        af_d = par_val;
      idx_d = ~idx_q;
    end else if (ser_en) begin
      {af_d, ae_d} = {ser_in, af_q, ae_q[OW-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    ae_q <= ae_d;
    af_q <= af_d;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) idx_q <= 1'b0;
    else        idx_q <= idx_d;
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;

  p_defaults_r7: assert property (@(posedge clk)
    !mrst_n |=> (ae_q == af_q) && (ae_q == LO || ae_q == HI));

  p_par_load_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    ld_par |=> (ae_q == $past(par_val)) || (af_q == $past(par_val)));
endmodule

// File: rtl/dcf_rd.sv
module dcf_rd #(
  parameter int AW = 8,
  parameter int W  = 18
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_ofs,
  input  logic [W-1:0]  mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  dout,
  output logic          rd_stat,
  output logic          ae
);
  import dcf_pkg::*;
  localparam int AW1 = AW + 1;
  localparam logic [AW1-1:0] CAP = AW1'(1 << AW);

  tmode_e         mode_q;
  logic [AW1-1:0] rbin_q, rbin_d, rgray_q, wbin_s, rcnt;
  logic [W-1:0]   q_q, q_d;
  logic           empty, pop;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= tmode_e'(fwft_sel);
  end

  assign wbin_s = AW1'(from_gray(32'(wgray_s)));
  assign rcnt   = wbin_s - rbin_q;
  assign empty  = (rcnt == '0);
  assign pop    = ren & ~empty;

  always_comb begin
    rbin_d = rbin_q;
    q_d    = q_q;
    if (rt) begin
      rbin_d = '0;
    end else if (pop) begin
      rbin_d = rbin_q + 1'b1;
      if (mode_q == TM_STD) q_d = mem_q;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= AW1'(to_gray(32'(rbin_d)));
      q_q     <= q_d;
    end
  end

  assign raddr   = rbin_q[AW-1:0];
  assign rgray   = rgray_q;
  assign dout    = (mode_q == TM_FWFT) ? mem_q : q_q;
  assign rd_stat = (mode_q == TM_FWFT) ? ~empty : empty;
  assign ae      = (rcnt <= {1'b0, ae_ofs});

  p_rcnt_bound_r1: assert property (@(posedge clk) disable iff (!clr_n)
    rcnt <= CAP);

  p_empty_ae_r6: assert property (@(posedge clk) disable iff (!clr_n)
    empty |-> ae);

  p_rgray_step_r12: assert property (@(posedge clk) disable iff (!clr_n)
    !$past(rt) |-> $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DEPTH  = 256,
  parameter int W      = 18,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 63
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrst_n,
  input  logic         prst_n,
  input  logic         fwft_sel,
  input  logic         def_sel,
  input  logic [W-1:0] din,
  input  logic         wen,
  input  logic         ld_par,
  input  logic         ser_en,
  input  logic         ser_in,
  output logic         wr_stat,
  output logic         af,
  output logic         hf,
  input  logic         ren,
  input  logic         rt,
  output logic [W-1:0] dout,
  output logic         rd_stat,
  output logic         ae
);
  import dcf_pkg::*;
  localparam int AW  = $clog2(DEPTH);
  localparam int AW1 = AW + 1;
  localparam logic [AW1-1:0] CAP  = AW1'(DEPTH);
  localparam logic [AW1-1:0] HALF = AW1'(DEPTH / 2);

  logic           clr_raw, w_clr_n, w_mrst_n, r_clr_n, r_mrst_n;
  tmode_e         w_mode;
  logic [AW-1:0]  ae_ofs, af_ofs, raddr;
  logic [AW1-1:0] wbin_q, wbin_d, wgray_q, wgray_s, rgray, rgray_s;
  logic [AW1-1:0] rbin_s, wcnt, space;
  logic           full, push;
  logic [W-1:0]   mem [DEPTH];

  assign clr_raw = mrst_n & prst_n;

  dcf_sync #(.W(1)) u_wclr  (.clk(wclk), .rst_n(clr_raw), .d(1'b1), .q(w_clr_n));
  dcf_sync #(.W(1)) u_wmrst (.clk(wclk), .rst_n(mrst_n),  .d(1'b1), .q(w_mrst_n));
  dcf_sync #(.W(1)) u_rclr  (.clk(rclk), .rst_n(clr_raw), .d(1'b1), .q(r_clr_n));
  dcf_sync #(.W(1)) u_rmrst (.clk(rclk), .rst_n(mrst_n),  .d(1'b1), .q(r_mrst_n));

  dcf_sync #(.W(AW1)) u_rg2w (.clk(wclk), .rst_n(w_clr_n), .d(rgray),   .q(rgray_s));
  dcf_sync #(.W(AW1)) u_wg2r (.clk(rclk), .rst_n(r_clr_n), .d(wgray_q), .q(wgray_s));

  always_ff @(posedge wclk) begin
    if (!w_mrst_n) w_mode <= tmode_e'(fwft_sel);
  end

  dcf_offsets #(.OW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_ofs (
    .clk(wclk), .clr_n(w_clr_n), .mrst_n(w_mrst_n), .def_sel(def_sel),
    .ld_par(ld_par), .par_val(din[AW-1:0]), .ser_en(ser_en), .ser_in(ser_in),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs));

  assign rbin_s = AW1'(from_gray(32'(rgray_s)));
  assign wcnt   = wbin_q - rbin_s;
  assign full   = (wcnt == CAP);
  assign space  = CAP - wcnt;
  assign push   = wen & ~ld_par & ~full;

  always_comb begin
    wbin_d = wbin_q;
    if (push) wbin_d = wbin_q + 1'b1;
  end

  always_ff @(posedge wclk or negedge w_clr_n) begin
    if (!w_clr_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= AW1'(to_gray(32'(wbin_d)));
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin_q[AW-1:0]] <= din;
  end

  assign wr_stat = (w_mode == TM_FWFT) ? ~full : full;
  assign af      = (space <= {1'b0, af_ofs});
  assign hf      = (wcnt > HALF);

  dcf_rd #(.AW(AW), .W(W)) u_rd (
    .clk(rclk), .clr_n(r_clr_n), .mrst_n(r_mrst_n), .fwft_sel(fwft_sel),
    .ren(ren), .rt(rt), .wgray_s(wgray_s), .ae_ofs(ae_ofs),
    .mem_q(mem[raddr]), .raddr(raddr), .rgray(rgray), .dout(dout),
    .rd_stat(rd_stat), .ae(ae));

  p_wcnt_bound_r2: assert property (@(posedge wclk) disable iff (!w_clr_n)
    wcnt <= CAP);

  p_full_af_r6: assert property (@(posedge wclk) disable iff (!w_clr_n)
    full |-> af);

  p_full_hf_r5: assert property (@(posedge wclk) disable iff (!w_clr_n)
    full |-> hf);

  p_wgray_step_r12: assert property (@(posedge wclk) disable iff (!w_clr_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: tb/dcfifo_pflag_test.sv
module dcfifo_pflag_test;
  localparam int DEPTH = 256;

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        mrst_n, prst_n, fwft_sel, def_sel;
  logic [17:0] din;
  logic        wen, ld_par, ser_en, ser_in, ren, rt;
  logic        wr_stat, af, hf, rd_stat, ae;
  logic [17:0] dout;

  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;
  bit          fwft_m;
  int          aofs_m, fofs_m;
  logic [17:0] sb[$];

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_pflag uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .def_sel(def_sel), .din(din), .wen(wen),
    .ld_par(ld_par), .ser_en(ser_en), .ser_in(ser_in), .wr_stat(wr_stat),
    .af(af), .hf(hf), .ren(ren), .rt(rt), .dout(dout), .rd_stat(rd_stat),
    .ae(ae));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_full();  return fwft_m ? !wr_stat : wr_stat; endfunction
  function automatic bit can_read(); return fwft_m ? rd_stat : !rd_stat; endfunction

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic do_mrst(input bit fw, input bit ds);
    @(negedge wclk);
    mrst_n = 1'b0; fwft_sel = fw; def_sel = ds;
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    mrst_n = 1'b1;
    sb.delete(); fwft_m = fw; aofs_m = ds ? 63 : 7; fofs_m = aofs_m;
    settle();
  endtask

  task automatic do_prst();
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (6) @(posedge wclk);
    repeat (6) @(posedge rclk);
    prst_n = 1'b1;
    sb.delete();
    settle();
  endtask

  task automatic push_word(input logic [17:0] d, output bit ok);
    @(negedge wclk);
    ok = !is_full();
    din = d; wen = 1'b1;
    if (ok) sb.push_back(d);
    @(posedge wclk); #1 wen = 1'b0;
  endtask

  task automatic pop_word(input string req);
    logic [17:0] e;
    @(negedge rclk);
    while (!can_read()) @(negedge rclk);
    if (sb.size() == 0) begin
      check(req, "unexpected extra word", 1, 0);
      return;
    end
    e = sb.pop_front();
    if (fwft_m) begin
      check(req, "fall-through dout", dout, e);
      ren = 1'b1; @(posedge rclk); #1 ren = 1'b0;
    end else begin
      ren = 1'b1; @(posedge rclk); #1 ren = 1'b0;
      @(negedge rclk);
      check(req, "dout", dout, e);
    end
  endtask

  task automatic fill_to(input int n);
    bit ok;
    while (sb.size() < n) push_word(18'($urandom), ok);
    settle();
  endtask

  task automatic drain();
    while (sb.size() > 0) pop_word("R1");
    settle();
  endtask

  task automatic flags(input string req);
    int c;
    c = sb.size();
    check(req, "rd_stat", rd_stat, fwft_m ? (c != 0) : (c == 0));
    check(req, "wr_stat", wr_stat, fwft_m ? (c != DEPTH) : (c == DEPTH));
    check(req, "hf", hf, c > DEPTH / 2);
    check(req, "ae", ae, c <= aofs_m);
    check(req, "af", af, (DEPTH - c) <= fofs_m);
  endtask

  task automatic par_load(input int v);
    @(negedge wclk);
    ld_par = 1'b1; wen = 1'b1; din = 18'(v);
    @(posedge wclk); #1 ld_par = 1'b0; wen = 1'b0;
  endtask

  task automatic ser_load(input logic [7:0] a, input logic [7:0] f);
    for (int i = 0; i < 16; i++) begin
      @(negedge wclk);
      ser_en = 1'b1;
      ser_in = (i < 8) ? a[i] : f[i-8];
    end
    @(negedge wclk); ser_en = 1'b0;
  endtask

  task automatic random_traffic(input int n, input string req);
    fork
      begin
        bit ok;
        for (int i = 0; i < n; i++) begin
          ok = 1'b0;
          while (!ok) push_word(18'($urandom), ok);
          repeat ($urandom % 3) @(negedge wclk);
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          pop_word(req);
          repeat ($urandom % 4) @(negedge rclk);
        end
      end
    join
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] hold, rtw[5];
    bit ok;
    void'($urandom(32'd4711));
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; def_sel = 1'b0;
    din = '0; wen = 1'b0; ld_par = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
    ren = 1'b0; rt = 1'b0;

    // R7: state after master reset, default offset 7
    do_mrst(1'b0, 1'b0);
    flags("R7");

    // R6: almost-empty crossing at the default offset
    fill_to(7);   flags("R6");
    fill_to(8);   flags("R6");
    // R5: half-full crossing
    fill_to(128); flags("R5");
    fill_to(129); flags("R5");
    // R6: almost-full crossing, R2: full
    fill_to(248); flags("R6");
    fill_to(249); flags("R6");
    fill_to(256); flags("R2");
    // R3: writes while full are dropped
    for (int i = 0; i < 3; i++) push_word(18'h3ffff, ok);
    check("R3", "sb size", sb.size(), DEPTH);
    settle(); flags("R3");
    drain(); flags("R1");

    // R3: read while empty leaves dout and pointer alone
    hold = dout;
    @(negedge rclk); ren = 1'b1; @(posedge rclk); #1 ren = 1'b0;
    @(negedge rclk); check("R3", "dout after empty read", dout, hold);
    push_word(18'h2a5a5, ok); settle();
    pop_word("R3"); settle(); flags("R3");

    // R9: parallel load, with a write attempted on the same edge
    par_load(20); par_load(30);
    aofs_m = 20; fofs_m = 30;
    settle(); flags("R9");
    fill_to(20);  flags("R9");
    fill_to(21);  flags("R9");
    fill_to(225); flags("R9");
    fill_to(226); flags("R9");

    // R8: partial reset keeps the programmed offsets
    do_prst(); flags("R8");
    fill_to(20);  flags("R8");
    fill_to(21);  flags("R8");

    // R7: master reset brings back defaults, select = 63
    do_mrst(1'b0, 1'b1); flags("R7");
    fill_to(63);  flags("R7");
    fill_to(64);  flags("R7");
    fill_to(192); flags("R7");
    fill_to(193); flags("R7");

    // R10: serial load, almost-empty field first, LSB first
    do_prst();
    ser_load(8'd5, 8'd10);
    aofs_m = 5; fofs_m = 10;
    settle(); flags("R10");
    fill_to(5);   flags("R10");
    fill_to(6);   flags("R10");
    fill_to(245); flags("R10");
    fill_to(246); flags("R10");
    drain();

    // R11: retransmit in standard timing
    do_prst();
    for (int i = 0; i < 5; i++) begin
      rtw[i] = 18'($urandom);
      push_word(rtw[i], ok);
    end
    settle();
    for (int i = 0; i < 3; i++) pop_word("R11");
    @(negedge rclk); rt = 1'b1; @(posedge rclk); #1 rt = 1'b0;
    sb.delete();
    for (int i = 0; i < 5; i++) sb.push_back(rtw[i]);
    settle(); flags("R11");
    for (int i = 0; i < 5; i++) pop_word("R11");
    settle(); flags("R11");

    // R1, R12: randomised traffic in standard timing
    random_traffic(300, "R12");
    flags("R1");

    // R4: fall-through timing
    do_mrst(1'b1, 1'b0); flags("R4");
    push_word(18'h1beef, ok); settle();
    check("R4", "ready without request", rd_stat, 1);
    check("R4", "word shown without request", dout, 18'h1beef);
    pop_word("R4"); settle(); flags("R4");
    fill_to(256); flags("R4");
    drain(); flags("R4");
    random_traffic(300, "R4");
    flags("R4");

    // R11: retransmit in fall-through timing
    do_prst();
    for (int i = 0; i < 4; i++) begin
      rtw[i] = 18'($urandom);
      push_word(rtw[i], ok);
    end
    settle();
    for (int i = 0; i < 4; i++) pop_word("R11");
    @(negedge rclk); rt = 1'b1; @(posedge rclk); #1 rt = 1'b0;
    for (int i = 0; i < 4; i++) sb.push_back(rtw[i]);
    settle(); flags("R11");
    for (int i = 0; i < 4; i++) pop_word("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule